// File: doc/BRIEF.md
# I/O Privilege Gate with Per-Port Permission Lookup

This block decides whether an instruction that is sensitive to the I/O privilege level may execute. The caller gives it the current privilege level, the I/O privilege level, whether the instruction is a port I/O access or a flag-changing instruction (the ones that clear, set or load the interrupt-enable flag), whether the task runs under a 32-bit or a 16-bit task state segment, and the port number and access width. The caller pulses `start`. One `done` pulse later reports either `allow` or `fault`, where `fault` means a general protection fault.

Most requests resolve from the privilege comparison alone. A lower number means more privilege, on a scale from 0 to 3. Only a port I/O instruction that runs with less privilege than the I/O level under a 32-bit task segment needs the per-port permission bitmap. In that case the block reads one bitmap byte per request through a plain read port with a request/valid handshake. It fetches a second byte when the access spans a byte boundary. Locating the bitmap inside the task segment is the caller's job: `mem_addr` is an offset in bytes from the bitmap start. Performing the actual I/O cycle is also outside the block.

Top module: `io_perm_check`

## Requirements
- R1: When `cpl` <= `iopl` (0 = most privileged), the request is allowed, `done` rises in the cycle after the `start` edge, and `mem_req` stays low.
- R2: When `cpl` > `iopl` and `tss32` = 0, the request faults in the cycle after the `start` edge without any bitmap read, whatever the instruction class.
- R3: When `cpl` > `iopl`, `tss32` = 1 and `is_port_io` = 0, the request faults in the cycle after the `start` edge without any bitmap read.
- R4: When `cpl` > `iopl`, `tss32` = 1 and `is_port_io` = 1, port p is looked up at bitmap byte offset p>>3, bit p&7 (bit 0 = LSB of `mem_data`). A bit value of 1 denies the port.
- R5: `size` selects the access width: 00 = 1 byte, 01 = 2 bytes, 10 or 11 = 4 bytes. The access covers ports p to p+width-1 (modulo 2^16). It is allowed only if every covered bit is 0.
- R6: When the covered ports reach into the next byte, the block reads byte p>>3 first and then the following byte (the byte offset wraps to 0 past the last byte). It reads the second byte even when the first already denies. It never reads more than two bytes.
- R7: `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_valid` high. `mem_valid` is ignored while `mem_req` is low.
- R8: `done` is a one-cycle pulse. Exactly one of `allow` and `fault` is high with it, and both are low whenever `done` is low.
- R9: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` while `busy` is high is ignored and produces no result.
- R10: After reset, `busy`, `done`, `allow`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken when not busy |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| is_port_io | input | 1 | 1 = port I/O instruction, 0 = flag-changing instruction |
| tss32 | input | 1 | 1 = 32-bit task segment, 0 = 16-bit |
| port | input | 16 | Port number |
| size | input | 2 | Access width code (00 = 1, 01 = 2, 1x = 4 bytes) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| allow | output | 1 | Access permitted (valid with done) |
| fault | output | 1 | General protection fault (valid with done) |
| mem_req | output | 1 | Bitmap byte read request |
| mem_addr | output | 13 | Bitmap byte offset |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_data | input | 8 | Bitmap byte |

## Verification
The assertions check several properties on every cycle:
- `done` is a one-cycle pulse carrying exactly one verdict.
- `allow` and `fault` stay quiet outside `done`.
- The read request holds with a stable address while it waits.
- `busy` does not drop before `done`.
- The two direct verdicts (privileged allow and 16-bit fault) arrive in the very next cycle with no read.

Only the scoreboard scenarios can show three further things:
- The verdict from the bitmap is correct for each access width.
- The fetch addresses and their order are correct, including the wrap at the top port.
- A `start` that arrives while busy leaves no trace in the results.

// File: rtl/io_perm_pkg.sv
// Shared types for the I/O privilege gate.
// Assumes privilege levels are small unsigned numbers, 0 = most privileged.
package io_perm_pkg;

    // Sequencer states of the gate
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH0 = 2'd1,
        ST_FETCH1 = 2'd2,
        ST_DONE   = 2'd3
    } io_state_e;

    // Resolution path chosen by the privilege policy
    typedef enum logic [1:0] {
        PATH_ALLOW = 2'd0,
        PATH_FAULT = 2'd1,
        PATH_MAP   = 2'd2
    } io_path_e;

    // Width code to a run of covered bits: 00 -> 1, 01 -> 2, 1x -> 4
    function automatic logic [7:0] width_run(input logic [1:0] code);
        logic [7:0] run;
        case (code)
            2'b00:   run = 8'h01;
            2'b01:   run = 8'h03;
            default: run = 8'h0F;
        endcase
        return run;
    endfunction

endpackage

// File: rtl/io_perm_policy.sv
// Privilege policy: picks direct allow, direct fault or a bitmap lookup.
// Purely combinational. Assumes both levels use the same encoding.
module io_perm_policy
    import io_perm_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic [PRIV_W-1:0] cpl,
    input  logic [PRIV_W-1:0] iopl,
    input  logic              is_port_io,
    input  logic              tss32,
    output io_path_e          path
);

    // Decide the path from the level comparison and the task segment kind
    always_comb begin
        if (cpl <= iopl)
            path = PATH_ALLOW;
        else if (tss32 && is_port_io)
            path = PATH_MAP;
        else
            path = PATH_FAULT;
    end

endmodule

// File: rtl/io_perm_span.sv
// Covered-bit geometry: turns a port and a width code into byte offsets
// and per-byte bit masks. At most two bytes are ever touched because the
// widest access is 4 ports. The second offset wraps modulo the bitmap size.
module io_perm_span
    import io_perm_pkg::*;
#(
    parameter int PORT_W = 16,
    localparam int BADDR_W = PORT_W - 3
) (
    input  logic [PORT_W-1:0]  port,
    input  logic [1:0]         size,
    output logic [BADDR_W-1:0] addr_first,
    output logic [BADDR_W-1:0] addr_next,
    output logic [7:0]         mask_first,
    output logic [7:0]         mask_next,
    output logic               spans_two
);

    logic [15:0] window;

    // Slide the run of covered bits to the starting bit of the port
    always_comb begin
        window     = {8'h00, width_run(size)} << port[2:0];
        mask_first = window[7:0];
        mask_next  = window[15:8];
        spans_two  = |window[15:8];
    end

    // Byte offsets of the first and following bitmap bytes
    always_comb begin
        addr_first = port[PORT_W-1:3];
        addr_next  = addr_first + BADDR_W'(1);
    end

endmodule

// File: rtl/io_perm_check.sv
// I/O privilege gate top. It latches a request on start when idle. It
// resolves the request directly or through up to two bitmap byte reads,
// then pulses done with one verdict. Assumes the memory holds mem_data
// valid only in the cycle it raises mem_valid while mem_req is high.
module io_perm_check
    import io_perm_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int PRIV_W = 2,
    localparam int BADDR_W = PORT_W - 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PRIV_W-1:0]  cpl,
    input  logic [PRIV_W-1:0]  iopl,
    input  logic               is_port_io,
    input  logic               tss32,
    input  logic [PORT_W-1:0]  port,
    input  logic [1:0]         size,
    output logic               busy,
    output logic               done,
    output logic               allow,
    output logic               fault,
    output logic               mem_req,
    output logic [BADDR_W-1:0] mem_addr,
    input  logic               mem_valid,
    input  logic [7:0]         mem_data
);

    io_state_e          state;
    io_path_e           path;
    logic [PORT_W-1:0]  port_q;
    logic [1:0]         size_q;
    logic               deny_q;
    logic               verdict_q;
    logic [BADDR_W-1:0] addr_first, addr_next;
    logic [7:0]         mask_first, mask_next;
    logic               spans_two;
    logic               hit_first, hit_next;

    io_perm_policy #(.PRIV_W(PRIV_W)) u_policy (
        .cpl        (cpl),
        .iopl       (iopl),
        .is_port_io (is_port_io),
        .tss32      (tss32),
        .path       (path)
    );

    io_perm_span #(.PORT_W(PORT_W)) u_span (
        .port       (port_q),
        .size       (size_q),
        .addr_first (addr_first),
        .addr_next  (addr_next),
        .mask_first (mask_first),
        .mask_next  (mask_next),
        .spans_two  (spans_two)
    );

    // Deny hits in the returned byte for whichever fetch is active
    always_comb begin
        hit_first = |(mem_data & mask_first);
        hit_next  = |(mem_data & mask_next);
    end

    // Request sequencer: latch, resolve, fetch, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            port_q    <= '0;
            size_q    <= '0;
            deny_q    <= 1'b0;
            verdict_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        port_q <= port;
                        size_q <= size;
                        deny_q <= 1'b0;
                        case (path)
                            PATH_ALLOW: begin
                                verdict_q <= 1'b1;
                                state     <= ST_DONE;
                            end
                            PATH_MAP: begin
                                verdict_q <= 1'b0;
                                state     <= ST_FETCH0;
                            end
                            default: begin
                                verdict_q <= 1'b0;
                                state     <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_FETCH0: begin
                    if (mem_valid) begin
                        if (spans_two) begin
                            deny_q <= hit_first;
                            state  <= ST_FETCH1;
                        end else begin
                            verdict_q <= !hit_first;
                            state     <= ST_DONE;
                        end
                    end
                end
                ST_FETCH1: begin
                    if (mem_valid) begin
                        verdict_q <= !(deny_q || hit_next);
                        state     <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the sequencer state
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        allow    = done && verdict_q;
        fault    = done && !verdict_q;
        mem_req  = (state == ST_FETCH0) || (state == ST_FETCH1);
        mem_addr = (state == ST_FETCH1) ? addr_next : addr_first;
    end

endmodule

// File: rtl/io_perm_check_sva.sv
// Checker for the I/O privilege gate, bound to every instance of the top.
module io_perm_check_sva #(
    parameter int PORT_W = 16,
    parameter int PRIV_W = 2,
    localparam int BADDR_W = PORT_W - 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [PRIV_W-1:0]  cpl,
    input logic [PRIV_W-1:0]  iopl,
    input logic               is_port_io,
    input logic               tss32,
    input logic [PORT_W-1:0]  port,
    input logic [1:0]         size,
    input logic               busy,
    input logic               done,
    input logic               allow,
    input logic               fault,
    input logic               mem_req,
    input logic [BADDR_W-1:0] mem_addr,
    input logic               mem_valid,
    input logic [7:0]         mem_data
);

    // R1
    priv_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cpl <= iopl) |=> (done && allow && !mem_req));

    // R2
    seg16_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cpl > iopl && !tss32) |=> (done && fault && !mem_req));

    // R3
    flag_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cpl > iopl && tss32 && !is_port_io) |=> (done && fault && !mem_req));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (allow ^ fault));

    // R8
    quiet_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!allow && !fault));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && !mem_req));

endmodule

bind io_perm_check io_perm_check_sva #(.PORT_W(PORT_W), .PRIV_W(PRIV_W)) u_sva (.*);

// File: tb/io_perm_check_bench.sv
// Scoreboard bench: the driver queues expected verdicts and fetch lists,
// a monitor compares each done pulse against the queue head.
module io_perm_check_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PORT_W     = 16;
    localparam int BADDR_W    = PORT_W - 3;

    typedef struct {
        bit                 allow;
        int                 nfetch;
        logic [BADDR_W-1:0] a0;
        logic [BADDR_W-1:0] a1;
        bit                 direct;
        int                 start_cyc;
        string              req;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         cpl = '0;
    logic [1:0]         iopl = '0;
    logic               is_port_io = 1'b0;
    logic               tss32 = 1'b0;
    logic [PORT_W-1:0]  port = '0;
    logic [1:0]         size = '0;
    logic               busy, done, allow, fault, mem_req;
    logic [BADDR_W-1:0] mem_addr;
    logic               mem_valid = 1'b0;
    logic [7:0]         mem_data = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int lat    = 0;
    int wait_cnt = 0;
    exp_t sb[$];
    logic [BADDR_W-1:0] fetch_log[$];

    io_perm_check #(.PORT_W(PORT_W)) u_io_perm_check (
        .clk(clk), .rst_n(rst_n), .start(start), .cpl(cpl), .iopl(iopl),
        .is_port_io(is_port_io), .tss32(tss32), .port(port), .size(size),
        .busy(busy), .done(done), .allow(allow), .fault(fault),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Bitmap image: odd byte offsets deny their bits 0 and 7, except the top byte
    function automatic logic [7:0] bm(input logic [BADDR_W-1:0] a);
        return (a[0] && a != {BADDR_W{1'b1}}) ? 8'h81 : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Memory responder with programmable latency; logs every served offset
    always @(negedge clk) begin
        if (mem_req && !mem_valid) begin
            if (wait_cnt >= lat) begin
                mem_valid <= 1'b1;
                mem_data  <= bm(mem_addr);
                fetch_log.push_back(mem_addr);
                wait_cnt  = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            mem_valid <= 1'b0;
            mem_data  <= 8'hA5;
        end
    end

    // Monitor: compare each result with the scoreboard head
    always @(negedge clk) begin
        if (done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(allow == e.allow && fault == !e.allow, e.req, "verdict allow",
                    int'(allow), int'(e.allow));
                chk(fetch_log.size() == e.nfetch, e.req, "fetch count",
                    fetch_log.size(), e.nfetch);
                if (e.nfetch >= 1 && fetch_log.size() >= 1)
                    chk(fetch_log[0] == e.a0, "R4", "first offset",
                        int'(fetch_log[0]), int'(e.a0));
                if (e.nfetch == 2 && fetch_log.size() == 2)
                    chk(fetch_log[1] == e.a1, "R6", "second offset",
                        int'(fetch_log[1]), int'(e.a1));
                if (e.direct)
                    chk(cyc == e.start_cyc + 1, e.req, "done latency",
                        cyc - e.start_cyc, 1);
            end
            fetch_log.delete();
        end
    end

    // Build the expected item for the current inputs and pulse start
    task automatic issue(input logic [1:0] c, input logic [1:0] io, input bit pio,
                         input bit t32, input logic [15:0] p, input logic [1:0] sz,
                         input string req);
        exp_t e;
        int n;
        logic [15:0] last;
        @(negedge clk);
        cpl = c; iopl = io; is_port_io = pio; tss32 = t32; port = p; size = sz;
        e.req = req; e.start_cyc = cyc; e.a0 = '0; e.a1 = '0;
        if (c <= io) begin
            e.allow = 1'b1; e.nfetch = 0; e.direct = 1'b1;
        end else if (!(t32 && pio)) begin
            e.allow = 1'b0; e.nfetch = 0; e.direct = 1'b1;
        end else begin
            n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
            e.allow = 1'b1; e.direct = 1'b0;
            for (int k = 0; k < n; k++) begin
                logic [15:0] q;
                logic [7:0]  b;
                q = p + 16'(k);
                b = bm(q[15:3]);
                if (b[q[2:0]]) e.allow = 1'b0;
            end
            last = p + 16'(n - 1);
            e.a0 = p[15:3];
            e.a1 = last[15:3];
            e.nfetch = (e.a1 != e.a0) ? 2 : 1;
        end
        sb.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: quiet outputs under reset
        chk(!busy && !done && !allow && !fault && !mem_req, "R10", "reset outputs",
            int'({busy, done, allow, fault, mem_req}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: privileged requests allowed directly
        issue(2'd0, 2'd0, 1'b1, 1'b1, 16'h000F, 2'b00, "R1");
        issue(2'd3, 2'd3, 1'b0, 1'b0, 16'h0000, 2'b00, "R1");
        issue(2'd2, 2'd3, 1'b1, 1'b0, 16'h0008, 2'b10, "R1");
        // R2: 16-bit segment faults for both classes
        issue(2'd3, 2'd0, 1'b1, 1'b0, 16'h0000, 2'b00, "R2");
        issue(2'd2, 2'd1, 1'b0, 1'b0, 16'h0000, 2'b00, "R2");
        // R3: flag-changing instruction under 32-bit segment faults
        issue(2'd1, 2'd0, 1'b0, 1'b1, 16'h0000, 2'b00, "R3");

        // R4: single-byte lookups, allow and deny
        lat = 0;
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h0003, 2'b00, "R4");
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h000F, 2'b00, "R4");
        lat = 2;
        issue(2'd3, 2'd1, 1'b1, 1'b1, 16'h0008, 2'b00, "R4");
        // R5: widths within one byte and code 11
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h0003, 2'b10, "R5");
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h0006, 2'b01, "R5");
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h0009, 2'b11, "R5");
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h0010, 2'b10, "R5");
        // R6: boundary crossings, deny in the second or in the first byte
        lat = 1;
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h0007, 2'b01, "R6");
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h0005, 2'b11, "R6");
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h0016, 2'b10, "R6");
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'h000F, 2'b01, "R6");
        // R6: wrap from the top byte back to offset 0
        issue(2'd3, 2'd0, 1'b1, 1'b1, 16'hFFFE, 2'b10, "R6");
        // R7: long latency hold
        lat = 3;
        issue(2'd3, 2'd2, 1'b1, 1'b1, 16'h0007, 2'b01, "R7");

        // R9: start while busy must be dropped
        lat = 3;
        begin
            exp_t e;
            @(negedge clk);
            cpl = 2'd3; iopl = 2'd0; is_port_io = 1'b1; tss32 = 1'b1;
            port = 16'h000F; size = 2'b00;
            e.req = "R9"; e.allow = 1'b0; e.nfetch = 1; e.a0 = 13'h0001;
            e.a1 = '0; e.direct = 1'b0; e.start_cyc = cyc;
            sb.push_back(e);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            chk(busy, "R9", "busy during fetch", int'(busy), 1);
            cpl = 2'd0; iopl = 2'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (busy) @(negedge clk);
            repeat (4) @(negedge clk);
            chk(!busy && !done, "R9", "no result from ignored start",
                int'({busy, done}), 0);
        end

        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R8", "all results delivered", sb.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule